// File: doc/BRIEF.md
# Sixteen-Level Vectored Interrupt Controller

This block sits beside the instruction sequencer of a 24-bit processor. It gathers sixteen external interrupt requests, each with its own enable bit, and gates all of them through one global enable flip-flop. A request is taken only when the sequencer signals an instruction boundary, which is the cycle in which the next instruction is fetched. When a request is taken, the block pulses a force strobe. The strobe tells the sequencer to put a generated instruction into the command register in place of the fetched word, and to keep the program counter unchanged so that the address of the displaced instruction is kept.

The generated instruction is an indirect branch-and-store-return. Its address field is the 6-bit code that the winning requester drives on the shared ID lines. That code selects one entry of a 63-word branch table in low memory, at addresses 1 to 63. Address 0 is never a valid vector: if the winner supplies code 0, it is still acknowledged, but the force strobe stays low and an error pulse is raised. Taking a request clears the global enable. The controller then ignores all requests until software sets the enable again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, ack_o, force_o, force_word_o and id_err_o are all zero, gie_o is 0 and every per-level enable bit is 0.
- R2: A high gie_set_i sets gie_o from the next cycle. A high gie_clr_i clears it. When both are high in the same cycle, gie_clr_i wins.
- R3: A request is taken only on a clock edge at which boundary_i is high. Pending requests are ignored when boundary_i is low.
- R4: A mask write (mask_wr_i high) loads mask_data_i into the per-level enables from the next cycle. Bit i set to 1 enables level i. A request on a level whose enable is 0 is ignored.
- R5: Among eligible requests, the lowest level index wins (level 0 has the highest priority).
- R6: On a take with a nonzero ID, force_o is high for exactly one cycle, in the cycle after the take edge. force_word_o then holds opcode 12 octal in bits 23:18, zero in bits 17:15, 1 in bit 14 (indirect) and the zero-extended ID in bits 13:0. Otherwise force_word_o is zero.
- R7: ack_o is one-hot on the winning level for exactly one cycle, in the cycle after the take edge, and zero at all other times.
- R8: A take clears the global enable from the next cycle. This clear overrides a gie_set_i given in the same cycle. No further take occurs until the enable is set again.
- R9: A take whose ID is 0 still acknowledges the winner, leaves force_o low, and pulses id_err_o high for that one cycle.
- R10: While gie_o is 0, no request is taken, whatever the boundary and mask state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Request lines, one per level |
| ack_o | output | 16 | One-cycle acknowledge to the winning level |
| id_i | input | 6 | Identification code from the winning requester |
| mask_wr_i | input | 1 | Load per-level enables |
| mask_data_i | input | 16 | New per-level enable bits |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable |
| boundary_i | input | 1 | Instruction-boundary strobe |
| force_o | output | 1 | Load the forced word and hold the program counter |
| force_word_o | output | 24 | Forced branch-and-store-return instruction |
| id_err_o | output | 1 | Winner supplied the invalid code 0 |
| gie_o | output | 1 | Current global enable state |

## Verification
The bench targets four hazards:
- Simultaneous requests on high and low levels, with and without the low level masked. A priority encoder built the wrong way round would acknowledge level 15 or a masked level.
- A request held high after its acknowledge, sampled at later boundaries. A controller that did not drop its global enable when taking the request would take the same request again.
- A set command in the same cycle as a take, and set and clear together. Wrong precedence would leave the controller re-armed.
- Code 0 and code 63 from the requester. These expose a design that branches through location 0 or truncates the vector field.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 14;
  localparam int XFLD_W = 3;
  localparam int OPC_W  = 6;
  localparam logic [OPC_W-1:0] BSR_OPC = 6'o12;

  // Forced indirect branch-and-store-return: opcode, no index, indirect, vector
  function automatic logic [WORD_W-1:0] make_forced_word(input logic [ADDR_W-1:0] vec);
    return {BSR_OPC, {XFLD_W{1'b0}}, 1'b1, vec};
  endfunction
endpackage

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int NUM_LVL = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_wr,
  input  logic [NUM_LVL-1:0] mask_data,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               take,
  input  logic [NUM_LVL-1:0] req,
  output logic [NUM_LVL-1:0] mask_q,
  output logic               gie_q,
  output logic [NUM_LVL-1:0] eligible
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_data;
      if (gie_clr || take) gie_q <= 1'b0;
      else if (gie_set)    gie_q <= 1'b1;
    end
  end

  assign eligible = req & mask_q & {NUM_LVL{gie_q}};
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LVL = 16
) (
  input  logic [NUM_LVL-1:0] vec,
  output logic [NUM_LVL-1:0] grant,
  output logic               any
);
  logic [NUM_LVL:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign grant[g]  = vec[g] & ~seen[g];
    assign seen[g+1] = seen[g] | vec[g];
  end

  assign any = seen[NUM_LVL];
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_LVL = 16,
  parameter int ID_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] req_i,
  output logic [NUM_LVL-1:0] ack_o,
  input  logic [ID_W-1:0]    id_i,
  input  logic               mask_wr_i,
  input  logic [NUM_LVL-1:0] mask_data_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               boundary_i,
  output logic               force_o,
  output logic [WORD_W-1:0]  force_word_o,
  output logic               id_err_o,
  output logic               gie_o
);
  localparam int PAD_W = ADDR_W - ID_W;

  logic [NUM_LVL-1:0] mask_q;
  logic               gie_q;
  logic [NUM_LVL-1:0] eligible_w;
  logic [NUM_LVL-1:0] grant_w;
  logic               any_w;
  logic               take_w;
  logic               id_ok_w;

  irq_mask_gate #(.NUM_LVL(NUM_LVL)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (mask_wr_i),
    .mask_data (mask_data_i),
    .gie_set   (gie_set_i),
    .gie_clr   (gie_clr_i),
    .take      (take_w),
    .req       (req_i),
    .mask_q    (mask_q),
    .gie_q     (gie_q),
    .eligible  (eligible_w)
  );

  irq_prio_pick #(.NUM_LVL(NUM_LVL)) u_pick (
    .vec   (eligible_w),
    .grant (grant_w),
    .any   (any_w)
  );

  assign take_w  = boundary_i & any_w;
  assign id_ok_w = (id_i != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_o        <= '0;
      force_o      <= 1'b0;
      force_word_o <= '0;
      id_err_o     <= 1'b0;
    end else begin
      ack_o        <= take_w ? grant_w : '0;
      force_o      <= take_w & id_ok_w;
      id_err_o     <= take_w & ~id_ok_w;
      force_word_o <= (take_w & id_ok_w) ? make_forced_word({{PAD_W{1'b0}}, id_i}) : '0;
    end
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_LVL = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_LVL-1:0] req_i,
  input logic               boundary_i,
  input logic [NUM_LVL-1:0] ack_o,
  input logic               force_o,
  input logic [23:0]        force_word_o,
  input logic               id_err_o,
  input logic               gie_o,
  input logic [NUM_LVL-1:0] mask_q
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack_o)); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (ack_o != '0) |=> (ack_o == '0)); // R7
  AST_FORCE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) force_o |-> (ack_o != '0)); // R6
  AST_FORCE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n) force_o |-> (force_word_o[23:14] == {6'o12, 3'b000, 1'b1})); // R6
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(force_o && id_err_o)); // R9
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) id_err_o |-> (ack_o != '0)); // R9
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) (ack_o != '0) |-> $past(boundary_i)); // R3
  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n) (ack_o != '0) |-> $past(gie_o)); // R10
  AST_TAKE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) (ack_o != '0) |-> !gie_o); // R8
  AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) (ack_o != '0) |-> ((ack_o & ~$past(req_i & mask_q)) == '0)); // R4
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_LVL(NUM_LVL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .boundary_i   (boundary_i),
  .ack_o        (ack_o),
  .force_o      (force_o),
  .force_word_o (force_word_o),
  .id_err_o     (id_err_o),
  .gie_o        (gie_o),
  .mask_q       (mask_q)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic [15:0] ack_o;
  logic [5:0]  id_i = '0;
  logic        mask_wr_i = 1'b0;
  logic [15:0] mask_data_i = '0;
  logic        gie_set_i = 1'b0;
  logic        gie_clr_i = 1'b0;
  logic        boundary_i = 1'b0;
  logic        force_o;
  logic [23:0] force_word_o;
  logic        id_err_o;
  logic        gie_o;

  int n_run = 0;
  int n_fail = 0;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o), .id_i(id_i),
    .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i), .gie_set_i(gie_set_i),
    .gie_clr_i(gie_clr_i), .boundary_i(boundary_i), .force_o(force_o),
    .force_word_o(force_word_o), .id_err_o(id_err_o), .gie_o(gie_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic        m_gie;
  logic [15:0] m_mask;
  logic [15:0] m_ack;
  logic        m_force;
  logic [23:0] m_word;
  logic        m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gie <= 0; m_mask <= 0; m_ack <= 0; m_force <= 0; m_word <= 0; m_err <= 0;
    end else begin
      int win;
      win = -1;
      if (m_gie && boundary_i)
        for (int i = 15; i >= 0; i--)
          if (req_i[i] && m_mask[i]) win = i;
      m_ack   <= (win >= 0) ? (16'd1 << win) : 16'd0;
      m_force <= (win >= 0) && (id_i != 0);
      m_err   <= (win >= 0) && (id_i == 0);
      m_word  <= ((win >= 0) && (id_i != 0)) ? ((24'o12 << 18) | (24'd1 << 14) | 24'(id_i)) : 24'd0;
      if (mask_wr_i) m_mask <= mask_data_i;
      if (gie_clr_i || win >= 0) m_gie <= 0;
      else if (gie_set_i)        m_gie <= 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 ack", 32'(ack_o), 32'(m_ack));
      check("R6 force", 32'(force_o), 32'(m_force));
      check("R6 word", 32'(force_word_o), 32'(m_word));
      check("R9 err", 32'(id_err_o), 32'(m_err));
      check("R2 gie", 32'(gie_o), 32'(m_gie));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_mask(input logic [15:0] m);
    mask_wr_i = 1; mask_data_i = m; step(); mask_wr_i = 0;
  endtask

  task automatic arm();
    gie_set_i = 1; step(); gie_set_i = 0;
  endtask

  // Drive a boundary for one cycle and return the ack seen after it
  task automatic boundary_pulse(output logic [15:0] seen);
    boundary_i = 1; step(); boundary_i = 0;
    seen = ack_o;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] a;
    repeat (3) step();
    rst_n = 1;
    step();
    check("R1 ack", 32'(ack_o), 0);
    check("R1 force", 32'(force_o), 0);
    check("R1 err", 32'(id_err_o), 0);
    check("R1 gie", 32'(gie_o), 0);

    // R10: global enable off blocks everything
    set_mask(16'hFFFF);
    req_i = 16'h0010; id_i = 6'd5;
    boundary_pulse(a);
    check("R10 no take while disarmed", 32'(a), 0);

    // R4: masked level ignored
    set_mask(16'h0000);
    arm();
    boundary_pulse(a);
    check("R4 masked level ignored", 32'(a), 0);
    check("R4 gie kept", 32'(gie_o), 1);

    // R3: no take without boundary
    set_mask(16'h0010);
    repeat (4) step();
    check("R3 no boundary no ack", 32'(ack_o), 0);
    boundary_pulse(a);
    check("R3 take at boundary", 32'(a), 32'h0010);
    check("R6 force word", 32'(force_word_o), 32'((24'o12 << 18) | (24'd1 << 14) | 24'd5));
    check("R8 gie cleared", 32'(gie_o), 0);
    step();
    check("R7 ack one cycle", 32'(ack_o), 0);
    // R8: request still held, no retake until re-armed
    boundary_pulse(a);
    check("R8 no retake", 32'(a), 0);
    req_i = 0;

    // R5: priority
    set_mask(16'hFFFF);
    arm();
    req_i = 16'h8F01; id_i = 6'o77;
    boundary_pulse(a);
    check("R5 level0 wins", 32'(a), 32'h0001);
    check("R6 vector 63", 32'(force_word_o[13:0]), 63);
    set_mask(16'hFFFE);
    arm();
    boundary_pulse(a);
    check("R5 level8 wins", 32'(a), 32'h0100);
    set_mask(16'h8000);
    arm();
    boundary_pulse(a);
    check("R5 level15 alone", 32'(a), 32'h8000);

    // R9: invalid id 0
    arm();
    id_i = 0;
    boundary_pulse(a);
    check("R9 ack on id0", 32'(a), 32'h8000);
    check("R9 no force", 32'(force_o), 0);
    check("R9 err pulse", 32'(id_err_o), 1);
    check("R9 word zero", 32'(force_word_o), 0);

    // R8: take overrides same-cycle set
    arm();
    id_i = 6'd9;
    gie_set_i = 1; boundary_i = 1; step(); gie_set_i = 0; boundary_i = 0;
    check("R8 take beats set", 32'(gie_o), 0);

    // R2: set and clear together
    gie_set_i = 1; gie_clr_i = 1; step(); gie_set_i = 0; gie_clr_i = 0;
    check("R2 clear wins", 32'(gie_o), 0);
    arm();
    check("R2 set", 32'(gie_o), 1);
    gie_clr_i = 1; step(); gie_clr_i = 0;
    check("R2 clear", 32'(gie_o), 0);
    req_i = 0;

    // Random traffic compared to the model each clock
    for (int k = 0; k < 3000; k++) begin
      req_i       = 16'($urandom);
      id_i        = ($urandom_range(0, 7) == 0) ? 6'd0 : 6'($urandom);
      boundary_i  = $urandom_range(0, 2) == 0;
      gie_set_i   = $urandom_range(0, 3) == 0;
      gie_clr_i   = $urandom_range(0, 9) == 0;
      mask_wr_i   = $urandom_range(0, 15) == 0;
      mask_data_i = 16'($urandom);
      step();
    end
    boundary_i = 0; gie_set_i = 0; gie_clr_i = 0; mask_wr_i = 0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule